// File: doc/BRIEF.md
# I2C Master Byte Controller

This block drives one I2C bus as its only master. Software writes a 16-bit control word to ask for START, repeated START and STOP conditions. It also uses that word to pick the transfer direction, the acknowledge level the master returns when reading, and a point in each byte where SCL is held low. One byte moves per transfer. Writing a data byte while the bus is held between bytes launches the next transfer. Status flags report byte completion, the target's acknowledge and a timeout, and an interrupt output combines those flags.

The bus side has two open-drain drive enables (1 pulls the line low) and two line inputs. SCL comes from a clock divider: four divider ticks make one SCL period. Data is sent most significant bit first. SDA changes only while SCL is low, except for START and STOP, which are SDA edges made while SCL is high. A START is generated only when both lines are seen high. A START or STOP request that cannot finish is dropped after a programmable number of cycles, if the timeout is enabled.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the control readback is 0x0002: the master-select bit (bit 1) is 1 and all other bits are 0. Bits 15:8 always read 0. Layout: bit0 enable, bit1 master-select, bit2 read mode, bit3 NACK-on-read, bit4 stretch enable, bit5 stretch after 8th edge, bit6 START request, bit7 STOP request. The controller runs only while enable and master-select are both 1.
- R2: A write that sets bits 6 and 7 together clears both request bits, and no condition appears on the bus.
- R3: A write that sets bit 6 while a STOP request is pending is ignored, and bit 6 reads 0 afterwards.
- R4: A START request raises `busy`, puts an SDA falling edge on the bus while SCL is high, and then clears bit 6. This also holds as a repeated START while `busy` is 1, in which case `busy` stays 1. A START waits until both lines are seen high.
- R5: A STOP request puts an SDA rising edge on the bus while SCL is high, then clears bit 7 and `busy`.
- R6: In write mode, a `tx_wr` while the bus is held sends `tx_data` MSB first over 8 SCL pulses and releases SDA on the 9th. At the 9th falling edge `byte_done` is set, and `ack_rx` shows the sampled 9th bit (1 = NACK).
- R7: In read mode, the 8 sampled bits appear on `rx_data` when `byte_done` rises. On the 9th bit the master releases SDA if bit 3 is 1 and pulls it low if bit 3 is 0.
- R8: With `tmo_en` high, a START or STOP request still pending after `TMO_CYC` cycles sets `tmo_flag`, clears both request bits, releases both lines and clears `busy`.
- R9: With bits 4 and 5 set, SCL is held low after the 8th falling edge until the next control write or `tx_wr`. The 9th bit follows that release.
- R10: With bit 4 set and bit 5 clear, SCL stays low after the 9th falling edge even if a byte was queued during the transfer. With bit 4 clear, a byte queued by `tx_wr` during a transfer follows at once.
- R11: While `busy` is 1, writes leave bits 0, 1 and 2 unchanged.
- R12: Writing enable = 0 while not busy cancels any pending request, and no START follows.
- R13: While a data bit is on the bus, SDA does not change while SCL is released.
- R14: `irq` equals `irq_en` AND (`byte_done` OR `tmo_flag`). A `flag_clr` pulse clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write value |
| reg_rdata | output | 16 | Control word readback |
| tx_wr | input | 1 | Data byte write strobe; launches or queues a byte |
| tx_data | input | 8 | Byte to transmit |
| rx_data | output | 8 | Last byte shifted in |
| tmo_en | input | 1 | Enables the request timeout |
| irq_en | input | 1 | Enables the interrupt output |
| flag_clr | input | 1 | Clears byte_done and tmo_flag |
| busy | output | 1 | Bus owned: set by START, cleared by STOP |
| byte_done | output | 1 | A byte with its 9th bit has completed |
| ack_rx | output | 1 | Acknowledge sampled in write mode (1 = NACK) |
| tmo_flag | output | 1 | A request timed out |
| irq | output | 1 | Interrupt |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The assertions check on every cycle that:
- SDA holds steady while a data bit has SCL released.
- `busy` rises only out of a START sequence.
- A START request written during a pending STOP never lands.
- The locked control bits stay put while busy.
- A timeout leaves no request pending.
- The SCL hold persists until software acts.

Only the bench's scenarios can show the bit order and acknowledge levels on the wire, the byte count between holds, continuation with a queued byte, and the absence of bus activity after an invalid request or a cancel. A small target model on the wired-AND lines observes these.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
    localparam int CB_EN   = 0;
    localparam int CB_MSEL = 1;
    localparam int CB_RD   = 2;
    localparam int CB_NACK = 3;
    localparam int CB_STON = 4;
    localparam int CB_ST8  = 5;
    localparam int CB_STA  = 6;
    localparam int CB_STP  = 7;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_WAIT, S_BIT, S_HOLD, S_STOP
    } bm_state_t;

    typedef struct packed {
        bm_state_t  st;
        logic [1:0] ph;
        logic [3:0] bitn;
        logic [7:0] sh;
        logic [7:0] nxt;
        logic [7:0] rx;
        logic       samp;
        logic       pend;
        logic       en;
        logic       msel;
        logic       rd;
        logic       nack;
        logic       str_on;
        logic       str8;
        logic       start;
        logic       stop;
        logic       busy;
        logic       done;
        logic       ackr;
        logic       tmo;
    } bm_regs_t;
endpackage

// File: rtl/i2c_bm_tick.sv
module i2c_bm_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q, cnt_d;

    assign tick = run && (cnt_q == CW'(DIV - 1));

    always_comb begin
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_bm_tmo.sv
module i2c_bm_tmo #(
    parameter int LIM = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = (LIM > 1) ? $clog2(LIM) : 1;

    logic [CW-1:0] cnt_q, cnt_d;

    assign expire = run && (cnt_q == CW'(LIM - 1));

    always_comb begin
        if (!run || expire) cnt_d = '0;
        else                cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8
    tmo_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !expire) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2c_bm_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int TMO_CYC = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        tx_wr,
    input  logic [7:0]  tx_data,
    output logic [7:0]  rx_data,
    input  logic        tmo_en,
    input  logic        irq_en,
    input  logic        flag_clr,
    output logic        busy,
    output logic        byte_done,
    output logic        ack_rx,
    output logic        tmo_flag,
    output logic        irq,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        scl_oe,
    output logic        sda_oe
);
    localparam logic [3:0] LAST_BIT = 4'd8;

    bm_regs_t q, d;
    logic     tick, expire, active;

    assign active = q.en && q.msel;

    i2c_bm_tick #(.DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(active), .tick(tick)
    );

    i2c_bm_tmo #(.LIM(TMO_CYC)) u_tmo (
        .clk(clk), .rst_n(rst_n),
        .run(tmo_en && active && (q.start || q.stop)), .expire(expire)
    );

    always_comb begin
        d = q;
        if (flag_clr) begin
            d.done = 1'b0;
            d.tmo  = 1'b0;
        end
        if (reg_wr) begin
            if (!q.busy) begin
                d.en   = reg_wdata[CB_EN];
                d.msel = reg_wdata[CB_MSEL];
                d.rd   = reg_wdata[CB_RD];
            end
            d.nack   = reg_wdata[CB_NACK];
            d.str_on = reg_wdata[CB_STON];
            d.str8   = reg_wdata[CB_ST8];
            if (reg_wdata[CB_STA] && reg_wdata[CB_STP]) begin
                d.start = 1'b0;
                d.stop  = 1'b0;
            end else begin
                if (reg_wdata[CB_STA] && !q.stop) d.start = 1'b1;
                if (reg_wdata[CB_STP])            d.stop  = 1'b1;
            end
        end
        if (tx_wr) begin
            d.nxt  = tx_data;
            d.pend = 1'b1;
        end
        if (!(d.en && d.msel)) begin
            d.start = 1'b0;
            d.stop  = 1'b0;
            d.pend  = 1'b0;
            d.st    = S_IDLE;
            d.ph    = 2'd0;
        end else if (expire) begin
            d.start = 1'b0;
            d.stop  = 1'b0;
            d.pend  = 1'b0;
            d.tmo   = 1'b1;
            d.busy  = 1'b0;
            d.st    = S_IDLE;
            d.ph    = 2'd0;
        end else begin
            unique case (q.st)
                S_IDLE: begin
                    d.pend = 1'b0;
                    if (d.start) begin
                        d.st = S_START;
                        d.ph = 2'd0;
                    end else begin
                        d.stop = 1'b0;
                    end
                end
                S_WAIT: begin
                    if (d.start) begin
                        d.st = S_START;
                        d.ph = 2'd0;
                    end else if (d.stop) begin
                        d.st = S_STOP;
                        d.ph = 2'd0;
                    end else if (tx_wr) begin
                        d.st   = S_BIT;
                        d.ph   = 2'd0;
                        d.bitn = 4'd0;
                        d.sh   = tx_data;
                        d.pend = 1'b0;
                    end
                end
                S_START: if (tick) begin
                    unique case (q.ph)
                        2'd0: d.ph = 2'd1;
                        2'd1: if (scl_in && sda_in) d.ph = 2'd2;
                        2'd2: d.ph = 2'd3;
                        default: begin
                            d.st    = S_WAIT;
                            d.ph    = 2'd0;
                            d.start = 1'b0;
                            d.busy  = 1'b1;
                            d.pend  = 1'b0;
                        end
                    endcase
                end
                S_STOP: if (tick) begin
                    unique case (q.ph)
                        2'd0: d.ph = 2'd1;
                        2'd1: if (scl_in) d.ph = 2'd2;
                        2'd2: d.ph = 2'd3;
                        default: begin
                            d.st   = S_IDLE;
                            d.ph   = 2'd0;
                            d.stop = 1'b0;
                            d.busy = 1'b0;
                        end
                    endcase
                end
                S_HOLD: begin
                    if (reg_wr || tx_wr) begin
                        d.st = S_BIT;
                        d.ph = 2'd0;
                    end
                end
                S_BIT: if (tick) begin
                    unique case (q.ph)
                        2'd0: d.ph = 2'd1;
                        2'd1: d.ph = 2'd2;
                        2'd2: begin
                            d.ph   = 2'd3;
                            d.samp = sda_in;
                        end
                        default: begin
                            d.ph = 2'd0;
                            if (q.bitn == LAST_BIT) begin
                                d.done = 1'b1;
                                d.rx   = q.sh;
                                if (!q.rd) d.ackr = q.samp;
                                if (d.pend && !(q.str_on && !q.str8)) begin
                                    d.bitn = 4'd0;
                                    d.sh   = d.nxt;
                                    d.pend = 1'b0;
                                end else begin
                                    d.st   = S_WAIT;
                                    d.pend = 1'b0;
                                end
                            end else begin
                                d.sh   = {q.sh[6:0], q.samp};
                                d.bitn = q.bitn + 1'b1;
                                if (q.bitn == 4'd7 && q.str_on && q.str8) d.st = S_HOLD;
                            end
                        end
                    endcase
                end
                default: d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.msel <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (q.st)
            S_WAIT, S_HOLD: scl_oe = 1'b1;
            S_START: begin
                scl_oe = (q.ph == 2'd3) || (q.ph == 2'd0 && q.busy);
                sda_oe = (q.ph == 2'd2) || (q.ph == 2'd3);
            end
            S_STOP: begin
                scl_oe = (q.ph == 2'd0);
                sda_oe = (q.ph == 2'd0) || (q.ph == 2'd1);
            end
            S_BIT: begin
                scl_oe = (q.ph == 2'd0) || (q.ph == 2'd3);
                if (q.bitn == LAST_BIT) sda_oe = q.rd && !q.nack;
                else                    sda_oe = !q.rd && !q.sh[7];
            end
            default: ;
        endcase
    end

    assign reg_rdata = {8'h00, q.stop, q.start, q.str8, q.str_on,
                        q.nack, q.rd, q.msel, q.en};
    assign rx_data   = q.rx;
    assign busy      = q.busy;
    assign byte_done = q.done;
    assign ack_rx    = q.ackr;
    assign tmo_flag  = q.tmo;
    assign irq       = irq_en && (q.done || q.tmo);

    // R13
    sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_BIT && $past(q.st == S_BIT) && !scl_oe && $past(!scl_oe))
        |-> $stable(sda_oe));

    // R4
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> $past(q.st == S_START));

    // R3
    start_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[CB_STA] && q.stop && !q.start) |=> !q.start);

    // R11
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |=> ($stable(q.en) && $stable(q.msel) && $stable(q.rd)));

    // R8
    tmo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (!q.start && !q.stop && !q.busy));

    // R9
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_HOLD && !reg_wr && !tx_wr && active) |=> (q.st == S_HOLD && scl_oe));
endmodule

// File: tb/i2c_byte_master_test.sv
`timescale 1ns/1ps
module i2c_byte_master_test;
    localparam int TMO = 64;
    localparam logic [15:0] EN = 16'h01, MS = 16'h02, RD = 16'h04, NK = 16'h08,
                            SON = 16'h10, S8 = 16'h20, STA = 16'h40, STP = 16'h80;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 0, tx_wr = 0, tmo_en = 0, irq_en = 0, flag_clr = 0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic [7:0] tx_data = '0, rx_data;
    logic busy, byte_done, ack_rx, tmo_flag, irq, scl_oe, sda_oe, scl_in, sda_in;
    logic tgt_pull = 1'b0, stuck_sda = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_in = ~scl_oe;
    assign sda_in = ~(sda_oe | tgt_pull | stuck_sda);

    i2c_byte_master #(.CLK_DIV(4), .TMO_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tx_wr(tx_wr), .tx_data(tx_data), .rx_data(rx_data),
        .tmo_en(tmo_en), .irq_en(irq_en), .flag_clr(flag_clr), .busy(busy),
        .byte_done(byte_done), .ack_rx(ack_rx), .tmo_flag(tmo_flag), .irq(irq),
        .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // target model
    int tb_bit = 9, ti = 0, starts = 0, stops = 0, sclr = 0;
    logic [7:0] cur = '0, got = '0;
    logic got_ack = 1'b0, nacked = 1'b0, tb_rd = 1'b0, tgt_ack_lo = 1'b1;
    logic [7:0] tgt_bytes [0:3];

    function automatic logic pull_for(int b, logic [7:0] c, logic rdm, logic acklo);
        if (b < 0 || b > 8) return 1'b0;
        if (rdm) return (b < 8) ? ~c[7 - b] : 1'b0;
        return (b == 8) ? acklo : 1'b0;
    endfunction

    always @(negedge sda_in) if (scl_in === 1'b1) begin
        starts++; tb_bit = -1; ti = 0; nacked = 1'b0; tgt_pull = 1'b0;
    end
    always @(posedge sda_in) if (scl_in === 1'b1) stops++;
    always @(posedge scl_in) begin
        sclr++;
        if (tb_bit >= 0 && tb_bit < 8) got = {got[6:0], sda_in};
        else if (tb_bit == 8) begin
            got_ack = sda_in;
            if (tb_rd && sda_in) nacked = 1'b1;
        end
    end
    always @(negedge scl_in) begin
        if (tb_bit != 9) begin
            if (tb_bit == 8 && nacked) tb_bit = 9;
            else begin
                tb_bit = (tb_bit == 8) ? 0 : tb_bit + 1;
                if (tb_bit == 0) begin cur = tgt_bytes[ti % 4]; ti++; end
            end
        end
        tgt_pull = pull_for(tb_bit, cur, tb_rd, tgt_ack_lo);
    end

    int total = 0, fails = 0;
    bit finished = 0;

    function automatic logic [15:0] ctl_img(logic en, logic ms, logic rd, logic nk,
                                            logic son, logic s8, logic sa, logic sp);
        return {8'h00, sp, sa, s8, son, nk, rd, ms, en};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [15:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask
    task automatic send(input logic [7:0] b);
        @(negedge clk); tx_wr = 1'b1; tx_data = b;
        @(negedge clk); tx_wr = 1'b0;
    endtask
    task automatic clr_flags();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    // which: 0 busy, 1 byte_done, 2 tmo_flag
    task automatic wait_for(input int which, input logic val);
        int n = 0;
        logic s;
        s = (which == 0) ? busy : (which == 1) ? byte_done : tmo_flag;
        while (s !== val && n < 3000) begin
            @(negedge clk); n++;
            s = (which == 0) ? busy : (which == 1) ? byte_done : tmo_flag;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int s0, k0;
        logic [7:0] b, b2;
        logic al;
        tgt_bytes[0] = '0; tgt_bytes[1] = '0; tgt_bytes[2] = '0; tgt_bytes[3] = '0;
        void'($urandom(32'h5eed_1234));
        idle(4); rst_n = 1'b1; idle(2);

        // R1 reset state
        chk(reg_rdata == 16'h0002, "R1 reset readback", reg_rdata, 16'h0002);
        chk(!scl_oe && !sda_oe && !busy, "R1 lines idle", {scl_oe, sda_oe, busy}, 0);

        // R2 conflicting request, all upper bits set
        s0 = starts;
        wr_ctl(16'hFF03 | STA | STP);
        chk(reg_rdata == ctl_img(1,1,0,0,0,0,0,0), "R2 both cleared", reg_rdata, 16'h0003);
        chk(reg_rdata[15:8] == 8'h00, "R1 upper bits zero", reg_rdata[15:8], 0);
        idle(100);
        chk(!busy && starts == s0, "R2 no bus activity", starts - s0, 0);

        // R4 start
        irq_en = 1'b1;
        wr_ctl(EN | MS | STA);
        chk(reg_rdata[6] == 1'b1, "R4 start pending", reg_rdata[6], 1);
        wait_for(0, 1'b1);
        chk(busy && reg_rdata[6] == 1'b0, "R4 start self-clear", reg_rdata, 16'h0003);
        chk(starts == s0 + 1, "R4 start edge", starts - s0, 1);

        // R11 lock while busy
        wr_ctl(RD);
        chk(reg_rdata[2:0] == 3'b011, "R11 locked bits", reg_rdata[2:0], 3);
        wr_ctl(EN | MS);

        // R6 random write bytes
        tb_rd = 1'b0;
        for (int i = 0; i < 16; i++) begin
            b = 8'($urandom); al = 1'($urandom);
            tgt_ack_lo = al;
            clr_flags();
            send(b);
            wait_for(1, 1'b1);
            chk(got == b, "R6 byte on wire", got, b);
            chk(ack_rx == ~al, "R6 ack captured", ack_rx, ~al);
        end
        chk(irq == 1'b1, "R14 irq on byte_done", irq, 1);
        clr_flags();
        chk(irq == 1'b0 && !byte_done, "R14 flag clear", irq, 0);

        // R5 stop with R3 blocked start
        s0 = stops; k0 = starts;
        wr_ctl(EN | MS | STP);
        wr_ctl(EN | MS | STA);
        chk(reg_rdata[6] == 1'b0 && reg_rdata[7] == 1'b1, "R3 start ignored", reg_rdata, 16'h0083);
        wait_for(0, 1'b0);
        chk(reg_rdata == 16'h0003, "R5 stop self-clear", reg_rdata, 16'h0003);
        chk(stops == s0 + 1, "R5 stop edge", stops - s0, 1);
        idle(80);
        chk(!busy && starts == k0, "R3 no restart", starts - k0, 0);

        // R7 read two bytes, ACK then NACK, then R4 repeated start
        tgt_bytes[0] = 8'($urandom); tgt_bytes[1] = 8'($urandom);
        wr_ctl(EN | MS | RD);
        tb_rd = 1'b1;
        wr_ctl(EN | MS | RD | STA);
        wait_for(0, 1'b1);
        clr_flags(); send(8'h00); wait_for(1, 1'b1);
        chk(rx_data == tgt_bytes[0], "R7 read byte 0", rx_data, tgt_bytes[0]);
        chk(got_ack == 1'b0, "R7 master ack", got_ack, 0);
        wr_ctl(EN | MS | RD | NK);
        clr_flags(); send(8'h00); wait_for(1, 1'b1);
        chk(rx_data == tgt_bytes[1], "R7 read byte 1", rx_data, tgt_bytes[1]);
        chk(got_ack == 1'b1, "R7 master nack", got_ack, 1);
        tb_rd = 1'b0; tgt_ack_lo = 1'b1;
        k0 = starts;
        wr_ctl(EN | MS | RD | NK | STA);
        idle(80);
        chk(busy && starts == k0 + 1 && reg_rdata[6] == 1'b0, "R4 repeated start",
            starts - k0, 1);
        wr_ctl(EN | MS | STP); wait_for(0, 1'b0);

        // R9 stretch after 8th falling edge
        wr_ctl(EN | MS | SON | S8 | STA); wait_for(0, 1'b1);
        b = 8'($urandom);
        clr_flags(); s0 = sclr; send(b);
        idle(250);
        chk(sclr - s0 == 8 && !byte_done && scl_oe, "R9 held after 8", sclr - s0, 8);
        wr_ctl(EN | MS | SON | S8);
        wait_for(1, 1'b1);
        chk(sclr - s0 == 9 && got == b, "R9 ninth after release", sclr - s0, 9);

        // R10 stretch after 9th: queued byte does not go out
        wr_ctl(EN | MS | SON);
        clr_flags(); s0 = sclr; b = 8'($urandom);
        send(b); idle(4); send(~b);
        wait_for(1, 1'b1); idle(200);
        chk(sclr - s0 == 9 && got == b, "R10 stop at 9", sclr - s0, 9);

        // R10 stretch off: queued byte follows
        wr_ctl(EN | MS);
        clr_flags(); s0 = sclr; b = 8'($urandom); b2 = 8'($urandom);
        send(b); idle(4); send(b2);
        wait_for(1, 1'b1); clr_flags(); wait_for(1, 1'b1);
        chk(sclr - s0 == 18 && got == b2, "R10 continued byte", got, b2);
        wr_ctl(EN | MS | STP); wait_for(0, 1'b0);

        // R12 disable cancels stuck request
        stuck_sda = 1'b1; idle(2);
        k0 = starts;
        wr_ctl(EN | MS | STA); idle(60);
        chk(reg_rdata[6] && !busy, "R12 request stuck", reg_rdata, 16'h0043);
        wr_ctl(16'h0000);
        chk(reg_rdata == 16'h0000, "R12 cancelled", reg_rdata, 0);
        stuck_sda = 1'b0;
        wr_ctl(EN | MS); idle(100);
        chk(!busy && starts == k0, "R12 no start", starts - k0, 0);

        // R8 timeout
        stuck_sda = 1'b1; tmo_en = 1'b1; idle(2);
        clr_flags();
        wr_ctl(EN | MS | STA);
        wait_for(2, 1'b1);
        chk(tmo_flag && reg_rdata[7:6] == 2'b00 && !busy, "R8 timeout", reg_rdata, 16'h0003);
        chk(irq == 1'b1, "R14 irq on timeout", irq, 1);
        chk(!scl_oe && !sda_oe, "R8 lines released", {scl_oe, sda_oe}, 0);
        clr_flags();
        chk(!irq, "R14 timeout cleared", irq, 0);
        stuck_sda = 1'b0;

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule